// File: doc/BRIEF.md
# Frequency-Modulating Complex-Envelope Oscillator

This block turns a stream of signed baseband samples into a frequency-modulated complex envelope centred on a 0 Hz carrier. When a sample arrives, it is multiplied by a deviation gain. The scaled value is added to a running phase. The new phase is then wrapped back into the interval from -pi to pi.

The wrapped phase drives a rotation-mode CORDIC that runs inside the block. The CORDIC produces the cosine of the phase as the real output and the sine as the imaginary output. All angles and amplitudes are 16-bit two's-complement words with 13 fractional bits, so pi is the integer 25736. The CORDIC covers the whole circle: angles outside the first and fourth quadrants are first moved by pi, and the results are negated to match.

The iterations run one per clock. A strobe with each input sample starts a conversion. A one-cycle valid pulse marks each finished result. Samples offered while a conversion is still running are dropped.

Top module: `fm_nco`

## Requirements
- R1: While the asynchronous active-low reset is low, `env_vld`, `env_re` and `env_im` are 0 and the stored phase is 0.
- R2: A sample is accepted on a rising edge where `smp_vld` is 1 and no conversion is running. On acceptance the phase becomes the previous phase plus floor(`smp_data` * `dev_gain` / 8192).
- R3: If the sum in R2 exceeds 25736, then 51472 is subtracted from it. If the sum is below -25736, then 51472 is added. The stored phase always stays within -25736 to 25736.
- R4: An angle above 12868 has 25736 subtracted before the rotation. An angle below -12868 has 25736 added. When either correction is made, both outputs are negated, so the folded angle seen by the rotation lies within plus or minus 12868.
- R5: The rotation starts from x = 4975, y = 0 and z = the folded angle. It runs 13 steps, i = 0 to 12. In each step the direction d is +1 when z is at least 0 and -1 otherwise. Each step computes x' = x - d*(y>>>i), y' = y + d*(x>>>i) and z' = z - d*round(8192*atan(2^-i)). `env_re` is the final x and `env_im` is the final y, with the sign applied per R4. Each result is within 12 LSB of 8192*cos and 8192*sin of the phase.
- R6: `env_vld` is 1 for exactly one cycle. It rises on the 13th rising edge after the edge that accepted the sample, and `env_re`/`env_im` update on that same edge.
- R7: `smp_vld` is ignored while a conversion runs: the phase and the outputs are unaffected. A sample offered in the cycle that `env_vld` is high is accepted.
- R8: `env_re` and `env_im` hold their values in every cycle in which `env_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | New-sample strobe |
| smp_data | input | 16 | Signed baseband sample |
| dev_gain | input | 16 | Signed deviation gain, Q13 |
| env_re | output | 16 | Real part (cosine) of the envelope, Q13 |
| env_im | output | 16 | Imaginary part (sine) of the envelope, Q13 |
| env_vld | output | 1 | One-cycle result-valid pulse |

## Verification
The phase-range and fold-range properties assume that the scaled increment floor(`smp_data`*`dev_gain`/8192) never exceeds pi (25736) in magnitude. Under that assumption, one correction of 2*pi is enough to bring the phase back into range. The stimulus keeps `dev_gain` within plus or minus 8192 and the sample magnitude below 25736, so the increment always stays within that bound. Large same-sign steps are still used to force wraps in both directions and to force folds on both sides. Long runs with the strobe held high are used to show that samples arriving during a conversion are dropped.

// File: rtl/fmnco_pkg.sv
package fmnco_pkg;
  localparam int QFRAC     = 13;
  localparam int PI_Q      = 25736;
  localparam int HALF_PI_Q = PI_Q / 2;
  localparam int TWO_PI_Q  = 2 * PI_Q;
  localparam int KINV_Q    = 4975;

  // arctangent of 2^-idx in Q13 radians, rounded
  function automatic int atan_q(input int unsigned idx);
    case (idx)
      0:  atan_q = 6434;
      1:  atan_q = 3798;
      2:  atan_q = 2007;
      3:  atan_q = 1019;
      4:  atan_q = 511;
      5:  atan_q = 256;
      6:  atan_q = 128;
      7:  atan_q = 64;
      8:  atan_q = 32;
      9:  atan_q = 16;
      10: atan_q = 8;
      11: atan_q = 4;
      12: atan_q = 2;
      13: atan_q = 1;
      default: atan_q = 0;
    endcase
  endfunction
endpackage

// File: rtl/fmnco_phase_acc.sv
module fmnco_phase_acc
  import fmnco_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = QFRAC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] din,
  input  logic signed [W-1:0] dev,
  output logic signed [W-1:0] phase_q,
  output logic signed [W-1:0] phase_next
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] incr;
  logic signed [PW-1:0] sum;
  logic signed [W-1:0]  phase_d;

  always_comb begin
    prod = PW'(din) * PW'(dev);
    incr = prod >>> FRAC;
    sum  = PW'(phase_q) + incr;
    if (sum > PW'(PI_Q))
      phase_next = W'(sum - PW'(TWO_PI_Q));
    else if (sum < -PW'(PI_Q))
      phase_next = W'(sum + PW'(TWO_PI_Q));
    else
      phase_next = W'(sum);
    phase_d = load ? phase_next : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/fmnco_fold.sv
module fmnco_fold
  import fmnco_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] angle,
  output logic signed [W-1:0] z_fold,
  output logic                flip
);
  always_comb begin
    if (angle > W'(HALF_PI_Q)) begin
      z_fold = angle - W'(PI_Q);
      flip   = 1'b1;
    end else if (angle < -W'(HALF_PI_Q)) begin
      z_fold = angle + W'(PI_Q);
      flip   = 1'b1;
    end else begin
      z_fold = angle;
      flip   = 1'b0;
    end
  end
endmodule

// File: rtl/fmnco_cordic.sv
module fmnco_cordic
  import fmnco_pkg::*;
#(
  parameter int W     = 16,
  parameter int ITERS = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] z_in,
  input  logic                flip_in,
  output logic signed [W-1:0] re_o,
  output logic signed [W-1:0] im_o,
  output logic                rdy_o,
  output logic                busy_o
);
  localparam int CW = $clog2(ITERS + 1);

  logic signed [W-1:0] x_q, y_q, z_q, re_q, im_q;
  logic signed [W-1:0] x_d, y_d, z_d, re_d, im_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                flip_q, flip_d, busy_q, busy_d, rdy_q, rdy_d;
  logic signed [W-1:0] xs, ys, ang;

  always_comb begin
    xs     = x_q >>> cnt_q;
    ys     = y_q >>> cnt_q;
    ang    = W'(atan_q(32'(cnt_q)));
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    re_d   = re_q;
    im_d   = im_q;
    cnt_d  = cnt_q;
    flip_d = flip_q;
    busy_d = busy_q;
    rdy_d  = 1'b0;
    if (start) begin
      x_d    = W'(KINV_Q);
      y_d    = '0;
      z_d    = z_in;
      flip_d = flip_in;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (!z_q[W-1]) begin
        x_d = x_q - ys;
        y_d = y_q + xs;
        z_d = z_q - ang;
      end else begin
        x_d = x_q + ys;
        y_d = y_q - xs;
        z_d = z_q + ang;
      end
      if (cnt_q == CW'(ITERS - 1)) begin
        busy_d = 1'b0;
        rdy_d  = 1'b1;
        re_d   = flip_q ? -x_d : x_d;
        im_d   = flip_q ? -y_d : y_d;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      re_q   <= '0;
      im_q   <= '0;
      cnt_q  <= '0;
      flip_q <= 1'b0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
      re_q   <= re_d;
      im_q   <= im_d;
      cnt_q  <= cnt_d;
      flip_q <= flip_d;
      busy_q <= busy_d;
      rdy_q  <= rdy_d;
    end
  end

  assign re_o   = re_q;
  assign im_o   = im_q;
  assign rdy_o  = rdy_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/fm_nco.sv
module fm_nco #(
  parameter int W     = 16,
  parameter int ITERS = 13
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] smp_data,
  input  logic signed [W-1:0] dev_gain,
  output logic signed [W-1:0] env_re,
  output logic signed [W-1:0] env_im,
  output logic                env_vld
);
  logic                rst_meta, rst_sync_n;
  logic                busy, accept, flip;
  logic signed [W-1:0] phase, phase_next, fold_z;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign accept = smp_vld & ~busy;

  fmnco_phase_acc #(.W(W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept),
    .din        (smp_data),
    .dev        (dev_gain),
    .phase_q    (phase),
    .phase_next (phase_next)
  );

  fmnco_fold #(.W(W)) u_fold (
    .angle  (phase_next),
    .z_fold (fold_z),
    .flip   (flip)
  );

  fmnco_cordic #(.W(W), .ITERS(ITERS)) u_rot (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (accept),
    .z_in    (fold_z),
    .flip_in (flip),
    .re_o    (env_re),
    .im_o    (env_im),
    .rdy_o   (env_vld),
    .busy_o  (busy)
  );
endmodule

// File: rtl/fm_nco_chk.sv
module fm_nco_chk
  import fmnco_pkg::*;
#(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                accept,
  input logic                busy,
  input logic signed [W-1:0] phase,
  input logic signed [W-1:0] fold_z,
  input logic signed [W-1:0] env_re,
  input logic signed [W-1:0] env_im,
  input logic                env_vld
);
  // R3
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase <= W'(PI_Q)) && (phase >= -W'(PI_Q)));

  // R4
  a_r4_fold_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((fold_z <= W'(HALF_PI_Q)) && (fold_z >= -W'(HALF_PI_Q))));

  // R6
  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    env_vld |=> !env_vld);

  // R6
  a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R7
  a_r7_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(phase));

  // R8
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !env_vld |-> ($stable(env_re) && $stable(env_im)));
endmodule

bind fm_nco fm_nco_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .accept  (accept),
  .busy    (busy),
  .phase   (phase),
  .fold_z  (fold_z),
  .env_re  (env_re),
  .env_im  (env_im),
  .env_vld (env_vld)
);

// File: tb/fm_nco_test.sv
module fm_nco_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [W-1:0] smp_data = '0;
  logic signed [W-1:0] dev_gain = '0;
  logic signed [W-1:0] env_re, env_im;
  logic env_vld;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int mph = 0, mcnt = 0, exp_re = 0, exp_im = 0, pend_re = 0, pend_im = 0;
  int pend_ang = 0, cur_ang = 0;
  bit mbusy = 1'b0, exp_vld = 1'b0;
  int wrap_pos = 0, wrap_neg = 0, fold_cnt = 0;

  always #10 clk = ~clk;

  fm_nco uut (
    .clk(clk), .arst_n(arst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .dev_gain(dev_gain), .env_re(env_re), .env_im(env_im), .env_vld(env_vld)
  );

  task automatic ref_rotate(input int ang, output int re, output int im);
    int z, x, y, xn, a;
    bit f;
    z = ang; x = 4975; y = 0; f = 1'b0;
    if (z > 12868) begin z -= 25736; f = 1'b1; end
    else if (z < -12868) begin z += 25736; f = 1'b1; end
    if (f) fold_cnt++;
    for (int i = 0; i < 13; i++) begin
      a = $rtoi($atan(1.0 / (2.0 ** i)) * 8192.0 + 0.5);
      if (z >= 0) begin xn = x - (y >>> i); y = y + (x >>> i); z = z - a; end
      else        begin xn = x + (y >>> i); y = y - (x >>> i); z = z + a; end
      x = xn;
    end
    re = f ? -x : x;
    im = f ? -y : y;
  endtask

  always @(posedge clk or negedge arst_n) begin
    int inc;
    if (!arst_n) begin
      mph = 0; mcnt = 0; mbusy = 0; exp_vld = 0; exp_re = 0; exp_im = 0;
    end else begin
      exp_vld = 1'b0;
      if (mbusy) begin
        mcnt--;
        if (mcnt == 0) begin
          mbusy = 1'b0; exp_vld = 1'b1;
          exp_re = pend_re; exp_im = pend_im; cur_ang = pend_ang;
        end
      end else if (smp_vld) begin
        inc = (int'(smp_data) * int'(dev_gain)) >>> 13;
        mph = mph + inc;
        if (mph > 25736) begin mph -= 51472; wrap_pos++; end
        else if (mph < -25736) begin mph += 51472; wrap_neg++; end
        pend_ang = mph;
        ref_rotate(mph, pend_re, pend_im);
        mbusy = 1'b1; mcnt = 13;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    int cr, ci;
    check({tag, " R6 env_vld"}, int'(env_vld), int'(exp_vld));
    check({tag, " R5 R8 env_re"}, int'(env_re), exp_re);
    check({tag, " R5 R8 env_im"}, int'(env_im), exp_im);
    if (env_vld && exp_vld) begin
      cr = $rtoi($floor(8192.0 * $cos(real'(cur_ang) / 8192.0) + 0.5));
      ci = $rtoi($floor(8192.0 * $sin(real'(cur_ang) / 8192.0) + 0.5));
      checks++;
      if (int'(env_re) - cr > 12 || cr - int'(env_re) > 12 ||
          int'(env_im) - ci > 12 || ci - int'(env_im) > 12) begin
        fails++;
        $display("FAIL R5 accuracy actual=%0d,%0d expected=%0d,%0d",
                 env_re, env_im, cr, ci);
      end
    end
  endtask

  task automatic step(input bit v, input int d, input int g);
    @(negedge clk);
    compare();
    smp_vld  = v;
    smp_data = W'(d);
    dev_gain = W'(g);
  endtask

  task automatic send(input int d, input int g);
    step(1'b1, d, g);
    for (int k = 0; k < 15; k++) step(1'b0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1 reset env_vld", int'(env_vld), 0);
    check("R1 reset env_re", int'(env_re), 0);
    check("R1 reset env_im", int'(env_im), 0);
    arst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(1'b0, 0, 0);

    tag = "R1 R2";
    send(0, 0);
    send(-3, 100);
    send(5, -7);
    tag = "R2";
    for (int n = 0; n < 30; n++) send(1000, 8192);
    for (int n = 0; n < 20; n++) send(-700, 4096);
    tag = "R3 R4";
    for (int n = 0; n < 25; n++) send(20000, 8192);
    for (int n = 0; n < 25; n++) send(-23000, 8192);
    for (int n = 0; n < 15; n++) send(12000, -8192);
    tag = "R5";
    for (int n = 0; n < 80; n++)
      send($signed($urandom_range(50000)) - 25000, $urandom_range(8192));
    tag = "R7";
    for (int n = 0; n < 300; n++)
      step(1'b1, $signed($urandom_range(40000)) - 20000, 8192);
    for (int n = 0; n < 60; n++)
      step(n % 5 != 0, 3000 + n * 50, -8192);
    for (int k = 0; k < 20; k++) step(1'b0, 0, 0);

    checks++;
    if (wrap_pos == 0 || wrap_neg == 0) begin
      fails++;
      $display("FAIL R3 wrap coverage actual=%0d,%0d expected=nonzero", wrap_pos, wrap_neg);
    end
    checks++;
    if (fold_cnt == 0) begin
      fails++;
      $display("FAIL R4 fold coverage actual=%0d expected=nonzero", fold_cnt);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule